// File: doc/BRIEF.md
# Multi-channel DMA configuration register block

This block is the target side of a DMA controller with up to eight channels. It takes one 32-bit memory-mapped access at a time and splits the address into a channel index and a register select. For each channel it holds the transfer addresses, the byte count and an interrupt mask. It also tracks each channel's status code and answers reads with the stored values or the status. The data-moving engines sit outside the block. They receive a one-cycle start pulse, a one-cycle soft-reset pulse and the programmed addresses and length. They report completion back with a done pulse and a two-bit outcome code.

The peripheral occupies a 32 KB segment aligned on a 32 KB boundary, and each channel gets a 4 KB window inside it. Address bits [14:12] pick the channel and bits [4:0] pick the register. Bits [11:5] are not decoded, so an access whose address differs only in those bits reaches the same register. Register offsets within a channel window are: 0x00 source address, 0x04 destination address, 0x08 length (write) / status (read), 0x0C soft reset (write only), 0x10 interrupt mask.

Software starts a transfer by writing the length. It polls the status through the same offset, or waits for the channel interrupt. It acknowledges the interrupt with a write to the soft-reset register.

Top module: `mdma_cfg_regs`

## Requirements
- R1: After reset, every channel reads status 2 (idle) at offset 0x08, and every stored register reads zero. All interrupts, start pulses and reset pulses are low, and no response is pending.
- R2: The channel index is address bits [14:12] and the register select is bits [4:0]. Bits [11:5] are ignored, so addresses differing only there reach the same register.
- R3: An access whose address bits [31:15] differ from those of the segment base gets an error response with read data 0, and it changes no register.
- R4: A register select other than 0x00, 0x04, 0x08, 0x0C or 0x10, or a channel index not below the channel count, gets an error response and has no effect.
- R5: A read of the soft-reset register (0x0C) gets an error response.
- R6: Writes to the source (0x00) and destination (0x04) registers store the data with bits [1:0] cleared. The stored value is returned on read and driven to the engine.
- R7: A length write (0x08) to a channel that is not busy does three things on the next cycle: it stores the length with bits [1:0] cleared, it raises that channel's start output for exactly one cycle, and it makes the status read 4 (busy).
- R8: A length write to a busy channel is ignored. There is no start pulse and the stored length stays unchanged.
- R9: A done pulse on a busy channel sets its status from the outcome code: 00 gives 0 (success), 01 gives 1 (read error), 1x gives 3 (write error). A done pulse on a channel that is not busy has no effect.
- R10: A channel's interrupt is high while its status is 0, 1 or 3 and its mask register (0x10) holds zero. Any non-zero mask value holds it low. The mask reads back as written.
- R11: Any write to the soft-reset register (0x0C) returns the channel to idle (status 2), drops its interrupt and raises its reset output for one cycle.
- R12: Every request gets exactly one response in the next cycle. Write responses and error responses carry read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read data, 0 on writes and errors |
| ch_start_o | output | NUM_CH | One-cycle start pulse per channel |
| ch_reset_o | output | NUM_CH | One-cycle soft-reset pulse per channel |
| ch_src_o | output | 32*NUM_CH | Source address per channel |
| ch_dst_o | output | 32*NUM_CH | Destination address per channel |
| ch_len_o | output | 32*NUM_CH | Transfer length per channel |
| eng_done_i | input | NUM_CH | Engine completion pulse per channel |
| eng_code_i | input | 2*NUM_CH | Completion outcome per channel |
| irq_o | output | NUM_CH | Interrupt per channel |

## Verification
The access table mixes reads and writes across several channel windows. This separates correct storage from a decoder that drops the channel field or decodes the ignored middle address bits. Out-of-segment, undefined-offset, misaligned-offset and reset-register reads are interleaved with legal accesses, so that a missing error or a write that leaks into a register is seen on a later readback. Done pulses with each outcome code, on busy and idle channels, show the status mapping and the busy-only gating. Mask and reset writes around a completed channel show the interrupt gating and the acknowledge.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [2:0] {
    SEL_SRC,
    SEL_DST,
    SEL_LEN,
    SEL_RST,
    SEL_MASK,
    SEL_NONE
  } reg_sel_e;

  localparam logic [2:0] ST_SUCCESS = 3'd0;
  localparam logic [2:0] ST_RDERR   = 3'd1;
  localparam logic [2:0] ST_IDLE    = 3'd2;
  localparam logic [2:0] ST_WRERR   = 3'd3;
  localparam logic [2:0] ST_BUSY    = 3'd4;

  // engine outcome code to software-visible status
  function automatic logic [2:0] outcome_status(input logic [1:0] code);
    case (code)
      2'b00:   outcome_status = ST_SUCCESS;
      2'b01:   outcome_status = ST_RDERR;
      default: outcome_status = ST_WRERR;
    endcase
  endfunction

  function automatic logic finished(input logic [2:0] st);
    finished = (st == ST_SUCCESS) || (st == ST_RDERR) || (st == ST_WRERR);
  endfunction

endpackage

// File: rtl/mdma_addr_dec.sv
module mdma_addr_dec
  import mdma_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          NUM_CH   = 8,
  parameter logic [31:0] SEG_BASE = 32'h0004_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [2:0]        ch_idx,
  output reg_sel_e          sel,
  output logic              legal
);
  localparam int SEG_LSB = 15;

  logic seg_hit;
  logic ch_ok;
  logic unused_mid;

  assign unused_mid = ^addr[11:5];

  always_comb begin
    seg_hit = (addr[ADDR_W-1:SEG_LSB] == SEG_BASE[ADDR_W-1:SEG_LSB]);
    ch_idx  = addr[14:12];
    ch_ok   = (int'(ch_idx) < NUM_CH);
    case (addr[4:0])
      5'h00:   sel = SEL_SRC;
      5'h04:   sel = SEL_DST;
      5'h08:   sel = SEL_LEN;
      5'h0C:   sel = SEL_RST;
      5'h10:   sel = SEL_MASK;
      default: sel = SEL_NONE;
    endcase
    legal = seg_hit && ch_ok && (sel != SEL_NONE);
  end

endmodule

// File: rtl/mdma_chan_regs.sv
module mdma_chan_regs
  import mdma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done_i,
  input  logic [1:0]        code_i,
  output logic [DATA_W-1:0] src_o,
  output logic [DATA_W-1:0] dst_o,
  output logic [DATA_W-1:0] len_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [2:0]        status_o,
  output logic              start_o,
  output logic              reset_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] src_d, dst_d, len_d, mask_d, aligned;
  logic [2:0]        status_d;
  logic              start_d, reset_d, irq_d;

  assign aligned = {wdata[DATA_W-1:2], 2'b00};

  always_comb begin
    src_d    = src_o;
    dst_d    = dst_o;
    len_d    = len_o;
    mask_d   = mask_o;
    status_d = status_o;
    start_d  = 1'b0;
    reset_d  = 1'b0;
    if (done_i && status_o == ST_BUSY)
      status_d = outcome_status(code_i);
    if (wr_stb) begin
      case (sel)
        SEL_SRC:  src_d = aligned;
        SEL_DST:  dst_d = aligned;
        SEL_LEN: begin
          if (status_o != ST_BUSY) begin
            len_d    = aligned;
            status_d = ST_BUSY;
            start_d  = 1'b1;
          end
        end
        SEL_RST: begin
          status_d = ST_IDLE;
          reset_d  = 1'b1;
        end
        SEL_MASK: mask_d = wdata;
        default: ;
      endcase
    end
    irq_d = finished(status_d) && (mask_d == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_o    <= '0;
      dst_o    <= '0;
      len_o    <= '0;
      mask_o   <= '0;
      status_o <= ST_IDLE;
      start_o  <= 1'b0;
      reset_o  <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      src_o    <= src_d;
      dst_o    <= dst_d;
      len_o    <= len_d;
      mask_o   <= mask_d;
      status_o <= status_d;
      start_o  <= start_d;
      reset_o  <= reset_d;
      irq_o    <= irq_d;
    end
  end

endmodule

// File: rtl/mdma_rsp.sv
module mdma_rsp
  import mdma_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic                           req_write,
  input  logic                           acc_err,
  input  logic [2:0]                     ch_idx,
  input  reg_sel_e                       sel,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  src_all,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  dst_all,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  mask_all,
  input  logic [NUM_CH-1:0][2:0]         status_all,
  output logic                           rsp_valid,
  output logic                           rsp_err,
  output logic [DATA_W-1:0]              rsp_rdata
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    if (req_valid && !req_write && !acc_err) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_idx == 3'(c)) begin
          case (sel)
            SEL_SRC:  rd_d = src_all[c];
            SEL_DST:  rd_d = dst_all[c];
            SEL_LEN:  rd_d = DATA_W'(status_all[c]);
            SEL_MASK: rd_d = mask_all[c];
            default:  rd_d = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && acc_err;
      rsp_rdata <= rd_d;
    end
  end

endmodule

// File: rtl/mdma_cfg_regs.sv
module mdma_cfg_regs
  import mdma_pkg::*;
#(
  parameter int          NUM_CH   = 8,
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] SEG_BASE = 32'h0004_0000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rsp_valid,
  output logic                     rsp_err,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [NUM_CH-1:0]        ch_start_o,
  output logic [NUM_CH-1:0]        ch_reset_o,
  output logic [NUM_CH*DATA_W-1:0] ch_src_o,
  output logic [NUM_CH*DATA_W-1:0] ch_dst_o,
  output logic [NUM_CH*DATA_W-1:0] ch_len_o,
  input  logic [NUM_CH-1:0]        eng_done_i,
  input  logic [2*NUM_CH-1:0]      eng_code_i,
  output logic [NUM_CH-1:0]        irq_o
);
  logic [2:0] ch_idx;
  reg_sel_e   sel;
  logic       legal;
  logic       acc_err;

  logic [NUM_CH-1:0][DATA_W-1:0] src_all, dst_all, len_all, mask_all;
  logic [NUM_CH-1:0][2:0]        status_all;

  mdma_addr_dec #(
    .ADDR_W  (ADDR_W),
    .NUM_CH  (NUM_CH),
    .SEG_BASE(SEG_BASE)
  ) dec_i (
    .addr  (req_addr),
    .ch_idx(ch_idx),
    .sel   (sel),
    .legal (legal)
  );

  // the reset register has no read side
  assign acc_err = !legal || (!req_write && sel == SEL_RST);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_stb;
    assign wr_stb = req_valid && req_write && !acc_err && (ch_idx == 3'(c));

    mdma_chan_regs #(.DATA_W(DATA_W)) chan_i (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (wr_stb),
      .sel     (sel),
      .wdata   (req_wdata),
      .done_i  (eng_done_i[c]),
      .code_i  (eng_code_i[2*c +: 2]),
      .src_o   (src_all[c]),
      .dst_o   (dst_all[c]),
      .len_o   (len_all[c]),
      .mask_o  (mask_all[c]),
      .status_o(status_all[c]),
      .start_o (ch_start_o[c]),
      .reset_o (ch_reset_o[c]),
      .irq_o   (irq_o[c])
    );

    assign ch_src_o[c*DATA_W +: DATA_W] = src_all[c];
    assign ch_dst_o[c*DATA_W +: DATA_W] = dst_all[c];
    assign ch_len_o[c*DATA_W +: DATA_W] = len_all[c];
  end

  mdma_rsp #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W)
  ) rsp_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .acc_err   (acc_err),
    .ch_idx    (ch_idx),
    .sel       (sel),
    .src_all   (src_all),
    .dst_all   (dst_all),
    .mask_all  (mask_all),
    .status_all(status_all),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/mdma_cfg_regs_chk.sv
module mdma_cfg_regs_chk #(
  parameter int          NUM_CH   = 8,
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] SEG_BASE = 32'h0004_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [NUM_CH-1:0] ch_start_o,
  input logic [NUM_CH-1:0] ch_reset_o,
  input logic [NUM_CH-1:0] irq_o
);

  p_rsp_next_cycle_r12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_err_zero_data_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

  p_outside_segment_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_addr[ADDR_W-1:15] != SEG_BASE[ADDR_W-1:15])) |=> rsp_err);

  p_start_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_start_o));

  p_start_from_write_r7: assert property (@(posedge clk) disable iff (rst)
    (|ch_start_o) |-> $past(req_valid && req_write));

  p_reset_from_write_r11: assert property (@(posedge clk) disable iff (rst)
    (|ch_reset_o) |-> $past(req_valid && req_write));

  p_pulses_disjoint_r11: assert property (@(posedge clk) disable iff (rst)
    (ch_start_o & ch_reset_o) == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_irq
    p_irq_low_on_reset_r11: assert property (@(posedge clk) disable iff (rst)
      ch_reset_o[c] |-> !irq_o[c]);
  end

endmodule

bind mdma_cfg_regs mdma_cfg_regs_chk #(
  .NUM_CH  (NUM_CH),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .SEG_BASE(SEG_BASE)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .ch_start_o(ch_start_o),
  .ch_reset_o(ch_reset_o),
  .irq_o     (irq_o)
);

// File: tb/mdma_cfg_regs_tb_top.sv
`timescale 1ns/1ps
module mdma_cfg_regs_tb_top;
  localparam int NCH = 8;

  typedef struct packed {
    logic [23:0] tag;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic        err;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{" R6", 1'b1, 32'h0004_0000, 32'h1000_0003, 1'b0, 32'h0},          // src write, low bits dropped
    '{" R6", 1'b0, 32'h0004_0000, 32'h0,         1'b0, 32'h1000_0000},
    '{"R12", 1'b1, 32'h0004_2004, 32'hABCD_0008, 1'b0, 32'h0},          // dst ch2, write data 0
    '{" R2", 1'b0, 32'h0004_27E4, 32'h0,         1'b0, 32'hABCD_0008},  // alias via bits 11:5
    '{" R1", 1'b0, 32'h0004_2008, 32'h0,         1'b0, 32'h2},          // idle after reset
    '{" R7", 1'b1, 32'h0004_1008, 32'h0000_0041, 1'b0, 32'h0},          // start ch1
    '{" R7", 1'b0, 32'h0004_1008, 32'h0,         1'b0, 32'h4},          // busy
    '{" R8", 1'b1, 32'h0004_1008, 32'h0000_0080, 1'b0, 32'h0},          // ignored
    '{" R8", 1'b0, 32'h0004_1008, 32'h0,         1'b0, 32'h4},
    '{" R4", 1'b0, 32'h0004_0014, 32'h0,         1'b1, 32'h0},          // undefined offset
    '{" R5", 1'b0, 32'h0004_000C, 32'h0,         1'b1, 32'h0},          // read of reset reg
    '{" R3", 1'b1, 32'h0004_8000, 32'hDEAD_BEEC, 1'b1, 32'h0},          // outside segment
    '{" R3", 1'b0, 32'h0004_0000, 32'h0,         1'b0, 32'h1000_0000},  // ch0 src untouched
    '{" R4", 1'b0, 32'h0004_0002, 32'h0,         1'b1, 32'h0},          // misaligned offset
    '{"R10", 1'b1, 32'h0004_3010, 32'h0000_0005, 1'b0, 32'h0},          // mask ch3
    '{"R10", 1'b0, 32'h0004_3010, 32'h0,         1'b0, 32'h5},
    '{" R1", 1'b0, 32'h0004_7000, 32'h0,         1'b0, 32'h0}           // ch7 src still zero
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [31:0]       req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid, rsp_err;
  logic [31:0]       rsp_rdata;
  logic [NCH-1:0]    ch_start_o, ch_reset_o, irq_o;
  logic [NCH*32-1:0] ch_src_o, ch_dst_o, ch_len_o;
  logic [NCH-1:0]    eng_done_i = '0;
  logic [2*NCH-1:0]  eng_code_i = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic              got_valid, got_err;
  logic [31:0]       got_rdata;

  always #2 clk = ~clk;

  mdma_cfg_regs dut_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .ch_start_o(ch_start_o),
    .ch_reset_o(ch_reset_o),
    .ch_src_o  (ch_src_o),
    .ch_dst_o  (ch_dst_o),
    .ch_len_o  (ch_len_o),
    .eng_done_i(eng_done_i),
    .eng_code_i(eng_code_i),
    .irq_o     (irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one request at a falling edge, capture the response at the next one
  task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    got_valid = rsp_valid;
    got_err   = rsp_err;
    got_rdata = rsp_rdata;
  endtask

  task automatic done_pulse(input int ch, input logic [1:0] code);
    @(negedge clk);
    eng_done_i[ch]        = 1'b1;
    eng_code_i[2*ch +: 2] = code;
    @(negedge clk);
    eng_done_i = '0;
    eng_code_i = '0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
    check("R1 irq", 32'(irq_o), 32'h0);
    check("R1 start", 32'(ch_start_o), 32'h0);
    check("R1 reset pulse", 32'(ch_reset_o), 32'h0);
    check("R1 len out", 32'(|ch_len_o), 32'h0);
    check("R1 src out", 32'(|ch_src_o), 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].data);
      check($sformatf("%s vec%0d valid", VECS[i].tag, i), 32'(got_valid), 32'h1);
      check($sformatf("%s vec%0d err", VECS[i].tag, i), 32'(got_err), 32'(VECS[i].err));
      check($sformatf("%s vec%0d data", VECS[i].tag, i), got_rdata, VECS[i].rdata);
    end

    // R8 ignored length write left the first length; R6 source on the engine side
    check("R8 ch1 len", ch_len_o[32 +: 32], 32'h40);
    check("R6 ch0 src out", ch_src_o[31:0], 32'h1000_0000);
    check("R6 ch2 dst out", ch_dst_o[64 +: 32], 32'hABCD_0008);
    check("R7 ch1 start after table", 32'(ch_start_o), 32'h0);

    // R7 start pulse is one cycle on the written channel only
    access(1'b1, 32'h0004_4008, 32'h0000_0100);
    check("R7 start ch4", 32'(ch_start_o), 32'h10);
    @(negedge clk);
    check("R7 start drops", 32'(ch_start_o), 32'h0);
    check("R7 ch4 len", ch_len_o[128 +: 32], 32'h100);

    // R9 read error outcome, R10 interrupt raised
    done_pulse(4, 2'b01);
    check("R10 irq ch4 up", 32'(irq_o), 32'h10);
    access(1'b0, 32'h0004_4008, 32'h0);
    check("R9 ch4 status read error", got_rdata, 32'h1);

    // R10 mask holds the interrupt low, clearing it restores it
    access(1'b1, 32'h0004_4010, 32'h0000_0001);
    check("R10 irq ch4 masked", 32'(irq_o[4]), 32'h0);
    access(1'b1, 32'h0004_4010, 32'h0);
    check("R10 irq ch4 unmasked", 32'(irq_o[4]), 32'h1);

    // R11 soft reset acknowledges
    access(1'b1, 32'h0004_400C, 32'h1234_5678);
    check("R11 reset pulse ch4", 32'(ch_reset_o), 32'h10);
    check("R11 irq ch4 cleared", 32'(irq_o[4]), 32'h0);
    @(negedge clk);
    check("R11 reset pulse drops", 32'(ch_reset_o), 32'h0);
    access(1'b0, 32'h0004_4008, 32'h0);
    check("R11 ch4 idle", got_rdata, 32'h2);

    // R9 write error from code 1x on busy ch1
    done_pulse(1, 2'b10);
    access(1'b0, 32'h0004_1008, 32'h0);
    check("R9 ch1 status write error", got_rdata, 32'h3);
    check("R10 irq ch1 up", 32'(irq_o[1]), 32'h1);

    // R9 done on an idle channel has no effect
    done_pulse(5, 2'b00);
    access(1'b0, 32'h0004_5008, 32'h0);
    check("R9 ch5 stays idle", got_rdata, 32'h2);
    check("R9 irq ch5 low", 32'(irq_o[5]), 32'h0);

    // R10 masked channel completes without interrupt
    access(1'b1, 32'h0004_3008, 32'h0000_0008);
    done_pulse(3, 2'b00);
    access(1'b0, 32'h0004_3008, 32'h0);
    check("R9 ch3 success", got_rdata, 32'h0);
    check("R10 irq ch3 masked", 32'(irq_o[3]), 32'h0);

    finished = 1'b1;
    summary();
  end

endmodule